// File: doc/BRIEF.md
# Paged EEPROM Write Sequencer with Completion Polling

This block sits on the host side of a byte-wide parallel EEPROM. It drives the memory's active-low chip select, read strobe and write strobe, the address lines and a split data bus (output, output enable and input). Software or an upstream engine hands it one request at a time. A request is either a single-byte read, or a page load of 1 to 16 bytes that starts at a given address. The bytes of a page load then arrive on a separate byte stream.

For a page load, the block first checks that every byte falls inside one 16-byte page. It then pulses the write strobe once per byte, and keeps the spacing between successive strobes within the memory's byte-load window. After the last byte it waits for the window to close, so that the memory has begun programming. It then reads the last address repeatedly. While the memory is busy, bit 7 of that read comes back inverted. The sequencer finishes when bit 7 matches the written value, or when a polling budget runs out. Every strobe width, setup, hold, window and budget is a parameter given as a count of clock cycles.

Both request and data inputs use valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while nothing is in flight. A data byte is taken when `wd_valid` and `wd_ready` are both high. `wd_ready` is high only while the sequencer waits for the next byte of a page load. The upstream source must hold `wd_valid` and `wd_data` steady until the byte is taken. There is no back-pressure on the result: `rsp_valid` is a one-cycle pulse with plain status.

Top module: `eepw_ctrl`

## Requirements
- R1: After reset, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0, `req_ready` is 1, and `wd_ready` and `rsp_valid` are 0.
- R2: A write request is rejected with `rsp_status` = 1 and produces no write strobe if any of these holds: its count is 0, its count is above 16, or the low four address bits plus the count exceed 16.
- R3: Byte k of an accepted page load (k counted from 0 in stream order) is written at the start address plus k. All strobes of one load carry the same address bits above bit 3.
- R4: While `mem_we_n` is low, `mem_ce_n` is low and `mem_oe_n` is high. Each write strobe stays low for exactly PULSE_CYC cycles.
- R5: The data bus is driven (`mem_dq_oe` = 1) only while `mem_ce_n` is low and `mem_oe_n` is high. It is never driven during a read strobe.
- R6: Within one page load, the falling edges of `mem_we_n` are fewer than LOAD_WIN_CYC cycles apart.
- R7: If the byte stream leaves a pending byte unsupplied too long to meet R6, the load is aborted with `rsp_status` = 2, and no further write strobe is issued.
- R8: After the last byte of a load, the block reads the last written address until bit 7 of the read equals bit 7 of the written byte. It then reports `rsp_status` = 0 with that byte in `rsp_data`. It does not report success while the memory is still programming.
- R9: If completion is not seen within POLL_LIMIT_CYC cycles of the end of the load, the block reports `rsp_status` = 3.
- R10: A read request (`req_write` = 0) performs one read strobe, with `mem_ce_n` and `mem_oe_n` low and `mem_we_n` high. It returns the byte in `rsp_data` with `rsp_status` = 0.
- R11: `req_ready` and `wd_ready` are never high together. Each accepted request produces exactly one single-cycle `rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = page load, 0 = single read |
| req_addr | input | AW | Start (or read) address |
| req_count | input | 5 | Number of bytes in a page load |
| wd_valid | input | 1 | Data byte offered |
| wd_ready | output | 1 | Sequencer waiting for the next byte |
| wd_data | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_status | output | 2 | 0 ok, 1 range error, 2 stream stall, 3 timeout |
| rsp_data | output | 8 | Read byte, or final polled byte |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory read strobe, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | AW | Memory address |
| mem_dq_o | output | 8 | Data driven to the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_o` |
| mem_dq_i | input | 8 | Data returned by the memory |

## Verification
The properties assume that the byte stream obeys the valid/ready rule, holding each offered byte until it is taken. They also assume that the memory model drives `mem_dq_i` only from its own state and the current pins. The stimulus offers each byte at a falling clock edge and removes it only after the edge where `wd_ready` was seen high. In the stall case the bench simply stops offering bytes, which keeps the source legal. The memory model starts programming after a quiet gap shorter than the sequencer's settle delay, so polling always finds the device either busy or finished and never in the middle of a load.

// File: rtl/eepw_pkg.sv
package eepw_pkg;

  typedef enum logic [1:0] {
    RS_OK      = 2'd0,
    RS_RANGE   = 2'd1,
    RS_STALL   = 2'd2,
    RS_TIMEOUT = 2'd3
  } eepw_status_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_PULSE,
    PH_HOLD
  } eepw_phase_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD_WAIT,
    S_LOAD_BUSY,
    S_SETTLE,
    S_POLL_RD,
    S_POLL_GAP,
    S_READ
  } eepw_state_e;

endpackage

// File: rtl/eepw_timer.sv
module eepw_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  assign expired = (cnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (clear)
      cnt_q <= '0;
    else if (en && !expired)
      cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/eepw_bus_cycle.sv
module eepw_bus_cycle
  import eepw_pkg::*;
#(
  parameter int AW        = 11,
  parameter int DW        = 8,
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 20,
  parameter int HOLD_CYC  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_write,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] dq_i,
  output logic          ce_n,
  output logic          oe_n,
  output logic          we_n,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe,
  output logic          done,
  output logic [DW-1:0] rdata
);

  localparam int MAX_A = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int MAX_C = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
  localparam int CW    = $clog2(MAX_C + 1);

  eepw_phase_e   phase_q;
  logic [CW-1:0] cnt_q;
  logic          wr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [DW-1:0] rdata_q;
  logic          done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (start) begin
            phase_q <= PH_SETUP;
            cnt_q   <= CW'(SETUP_CYC - 1);
            wr_q    <= is_write;
            addr_q  <= addr;
            data_q  <= wdata;
          end
        end
        PH_SETUP: begin
          if (cnt_q == '0) begin
            phase_q <= PH_PULSE;
            cnt_q   <= CW'(PULSE_CYC - 1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_PULSE: begin
          if (cnt_q == '0) begin
            phase_q <= PH_HOLD;
            cnt_q   <= CW'(HOLD_CYC - 1);
            if (!wr_q)
              rdata_q <= dq_i;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_HOLD: begin
          if (cnt_q == '0) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign ce_n   = (phase_q == PH_IDLE);
  assign we_n   = !((phase_q == PH_PULSE) && wr_q);
  assign oe_n   = !((phase_q == PH_PULSE) && !wr_q);
  assign dq_oe  = wr_q && ((phase_q == PH_PULSE) || (phase_q == PH_HOLD));
  assign dq_o   = data_q;
  assign addr_o = addr_q;
  assign done   = done_q;
  assign rdata  = rdata_q;

endmodule

// File: rtl/eepw_ctrl.sv
module eepw_ctrl
  import eepw_pkg::*;
#(
  parameter int AW             = 11,
  parameter int PAGE_BYTES     = 16,
  parameter int SETUP_CYC      = 2,
  parameter int PULSE_CYC      = 20,
  parameter int HOLD_CYC       = 2,
  parameter int LOAD_WIN_CYC   = 3600,
  parameter int POLL_GAP_CYC   = 200,
  parameter int POLL_LIMIT_CYC = 2000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [4:0]    req_count,
  input  logic          wd_valid,
  output logic          wd_ready,
  input  logic [7:0]    wd_data,
  output logic          rsp_valid,
  output logic [1:0]    rsp_status,
  output logic [7:0]    rsp_data,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [7:0]    mem_dq_i
);

  localparam int OW        = $clog2(PAGE_BYTES);
  localparam int CNTW      = $clog2(PAGE_BYTES + 1);
  localparam int WW        = $clog2(LOAD_WIN_CYC + 1);
  localparam int GW        = $clog2(POLL_GAP_CYC + 1);
  localparam int PW        = $clog2(POLL_LIMIT_CYC + 1);
  localparam int STALL_LIM = LOAD_WIN_CYC - SETUP_CYC - PULSE_CYC - HOLD_CYC - 4;

  eepw_state_e   state_q;
  logic [AW-1:0] base_q;
  logic [OW-1:0] offs_q;
  logic [4:0]    left_q;
  logic [AW-1:0] last_addr_q;
  logic [7:0]    last_data_q;
  logic          rsp_valid_q;
  eepw_status_e  rsp_status_q;
  logic [7:0]    rsp_data_q;

  // request screening: the whole load must sit inside one page
  logic [CNTW:0] span;
  logic          range_ok;
  assign span     = (CNTW+1)'(req_addr[OW-1:0]) + (CNTW+1)'(req_count);
  assign range_ok = (req_count != '0) && (span <= (CNTW+1)'(PAGE_BYTES));

  logic accept, accept_wr;
  assign req_ready = (state_q == S_IDLE);
  assign wd_ready  = (state_q == S_LOAD_WAIT);
  assign accept    = req_valid && req_ready;
  assign accept_wr = accept && req_write && range_ok;

  // bus cycle engine
  logic          bus_start, bus_write, bus_done;
  logic [AW-1:0] bus_addr, load_addr;
  logic [7:0]    bus_rdata;
  logic          win_exp, gap_exp, poll_exp;

  assign load_addr = {base_q[AW-1:OW], offs_q};

  always_comb begin
    bus_start = 1'b0;
    bus_write = 1'b0;
    bus_addr  = last_addr_q;
    unique case (state_q)
      S_IDLE: begin
        bus_start = accept && !req_write;
        bus_addr  = req_addr;
      end
      S_LOAD_WAIT: begin
        bus_start = wd_valid;
        bus_write = 1'b1;
        bus_addr  = load_addr;
      end
      S_SETTLE:   bus_start = win_exp;
      S_POLL_GAP: bus_start = gap_exp;
      default:    bus_start = 1'b0;
    endcase
  end

  eepw_bus_cycle #(
    .AW(AW), .DW(8), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_bus (
    .clk(clk), .rst_n(rst_n), .start(bus_start), .is_write(bus_write),
    .addr(bus_addr), .wdata(wd_data), .dq_i(mem_dq_i),
    .ce_n(mem_ce_n), .oe_n(mem_oe_n), .we_n(mem_we_n), .addr_o(mem_addr),
    .dq_o(mem_dq_o), .dq_oe(mem_dq_oe), .done(bus_done), .rdata(bus_rdata)
  );

  // timers: byte-load window / settle, poll spacing, poll budget
  logic          load_end, last_load_end;
  logic [WW-1:0] win_limit;
  assign load_end      = (state_q == S_LOAD_BUSY) && bus_done;
  assign last_load_end = load_end && (left_q == 5'd1);
  assign win_limit     = (state_q == S_SETTLE) ? WW'(LOAD_WIN_CYC) : WW'(STALL_LIM);

  eepw_timer #(.W(WW)) u_win (
    .clk(clk), .rst_n(rst_n), .clear(accept_wr || load_end),
    .en((state_q == S_LOAD_WAIT) || (state_q == S_SETTLE)),
    .limit(win_limit), .expired(win_exp)
  );

  eepw_timer #(.W(GW)) u_gap (
    .clk(clk), .rst_n(rst_n), .clear((state_q == S_POLL_RD) && bus_done),
    .en(state_q == S_POLL_GAP), .limit(GW'(POLL_GAP_CYC)), .expired(gap_exp)
  );

  eepw_timer #(.W(PW)) u_budget (
    .clk(clk), .rst_n(rst_n), .clear(last_load_end),
    .en((state_q == S_SETTLE) || (state_q == S_POLL_RD) || (state_q == S_POLL_GAP)),
    .limit(PW'(POLL_LIMIT_CYC)), .expired(poll_exp)
  );

  // sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= S_IDLE;
      base_q       <= '0;
      offs_q       <= '0;
      left_q       <= '0;
      last_addr_q  <= '0;
      last_data_q  <= '0;
      rsp_valid_q  <= 1'b0;
      rsp_status_q <= RS_OK;
      rsp_data_q   <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (accept) begin
            if (!req_write) begin
              state_q <= S_READ;
            end else if (!range_ok) begin
              rsp_valid_q  <= 1'b1;
              rsp_status_q <= RS_RANGE;
              rsp_data_q   <= '0;
            end else begin
              base_q  <= req_addr;
              offs_q  <= req_addr[OW-1:0];
              left_q  <= req_count;
              state_q <= S_LOAD_WAIT;
            end
          end
        end
        S_LOAD_WAIT: begin
          if (wd_valid) begin
            last_addr_q <= load_addr;
            last_data_q <= wd_data;
            state_q     <= S_LOAD_BUSY;
          end else if (win_exp) begin
            rsp_valid_q  <= 1'b1;
            rsp_status_q <= RS_STALL;
            rsp_data_q   <= '0;
            state_q      <= S_IDLE;
          end
        end
        S_LOAD_BUSY: begin
          if (bus_done) begin
            offs_q  <= offs_q + 1'b1;
            left_q  <= left_q - 1'b1;
            state_q <= (left_q == 5'd1) ? S_SETTLE : S_LOAD_WAIT;
          end
        end
        S_SETTLE: begin
          if (win_exp)
            state_q <= S_POLL_RD;
        end
        S_POLL_RD: begin
          if (bus_done) begin
            if (bus_rdata[7] == last_data_q[7]) begin
              rsp_valid_q  <= 1'b1;
              rsp_status_q <= RS_OK;
              rsp_data_q   <= bus_rdata;
              state_q      <= S_IDLE;
            end else if (poll_exp) begin
              rsp_valid_q  <= 1'b1;
              rsp_status_q <= RS_TIMEOUT;
              rsp_data_q   <= bus_rdata;
              state_q      <= S_IDLE;
            end else begin
              state_q <= S_POLL_GAP;
            end
          end
        end
        S_POLL_GAP: begin
          if (gap_exp)
            state_q <= S_POLL_RD;
        end
        S_READ: begin
          if (bus_done) begin
            rsp_valid_q  <= 1'b1;
            rsp_status_q <= RS_OK;
            rsp_data_q   <= bus_rdata;
            state_q      <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign rsp_valid  = rsp_valid_q;
  assign rsp_status = rsp_status_q;
  assign rsp_data   = rsp_data_q;

endmodule

// File: rtl/eepw_ctrl_chk.sv
module eepw_ctrl_chk #(
  parameter int AW           = 11,
  parameter int PAGE_BYTES   = 16,
  parameter int PULSE_CYC    = 20,
  parameter int LOAD_WIN_CYC = 3600
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_ce_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          mem_dq_oe,
  input logic [AW-1:0] mem_addr,
  input logic          req_ready,
  input logic          wd_ready,
  input logic          rsp_valid
);

  localparam int OW = $clog2(PAGE_BYTES);

  logic          we_q;
  logic [31:0]   low_cnt;
  logic [31:0]   gap_cnt;
  logic          in_load;
  logic [AW-1:0] prev_addr;
  logic          we_fall, we_rise;

  assign we_fall = we_q && !mem_we_n;
  assign we_rise = !we_q && mem_we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q      <= 1'b1;
      low_cnt   <= '0;
      gap_cnt   <= '0;
      in_load   <= 1'b0;
      prev_addr <= '0;
    end else begin
      we_q    <= mem_we_n;
      low_cnt <= mem_we_n ? '0 : low_cnt + 1;
      if (we_fall)
        gap_cnt <= '0;
      else if (gap_cnt != 32'hFFFF_FFFF)
        gap_cnt <= gap_cnt + 1;
      if (we_fall) begin
        in_load   <= 1'b1;
        prev_addr <= mem_addr;
      end else if (rsp_valid) begin
        in_load <= 1'b0;
      end
    end
  end

  // R4: write strobe only inside a selected, non-reading cycle
  a_r4_we_framed: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n));

  // R4: strobe width
  a_r4_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    we_rise |-> (low_cnt == PULSE_CYC));

  // R5: no drive while reading or deselected
  a_r5_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n && !mem_ce_n));

  // R10: read strobe framing
  a_r10_read_framed: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_ce_n));

  // R6: byte-load window between write strobes
  a_r6_load_window: assert property (@(posedge clk) disable iff (!rst_n)
    (we_fall && in_load) |-> (gap_cnt < LOAD_WIN_CYC));

  // R3: one page per load
  a_r3_same_page: assert property (@(posedge clk) disable iff (!rst_n)
    (we_fall && in_load) |-> (mem_addr[AW-1:OW] == prev_addr[AW-1:OW]));

  // R11: handshake exclusivity and single-cycle result
  a_r11_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && wd_ready));

  a_r11_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

bind eepw_ctrl eepw_ctrl_chk #(
  .AW(AW), .PAGE_BYTES(PAGE_BYTES), .PULSE_CYC(PULSE_CYC), .LOAD_WIN_CYC(LOAD_WIN_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
  .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe), .mem_addr(mem_addr),
  .req_ready(req_ready), .wd_ready(wd_ready), .rsp_valid(rsp_valid)
);

// File: tb/tb_eepw_ctrl.sv
`timescale 1ns/1ps
module tb_eepw_ctrl;

  localparam int AW       = 11;
  localparam int PULSE    = 4;
  localparam int WIN      = 60;
  localparam int LIMIT    = 400;
  localparam int DEV_QUIET = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [4:0]    req_count = '0;
  logic          wd_valid = 1'b0;
  logic [7:0]    wd_data = '0;
  logic          req_ready, wd_ready, rsp_valid;
  logic [1:0]    rsp_status;
  logic [7:0]    rsp_data;
  logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_dq_o, mem_dq_i;

  eepw_ctrl #(
    .AW(AW), .PAGE_BYTES(16), .SETUP_CYC(2), .PULSE_CYC(PULSE), .HOLD_CYC(2),
    .LOAD_WIN_CYC(WIN), .POLL_GAP_CYC(8), .POLL_LIMIT_CYC(LIMIT)
  ) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_count(req_count),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_data(rsp_data),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // ---------------- memory model ----------------
  logic [7:0]    arr [2048];
  logic [7:0]    shadow [2048];
  logic [7:0]    pend_d [16];
  logic [15:0]   pend_m = '0;
  logic [AW-1:0] pend_pg = '0;
  logic [AW-1:0] last_a = '0;
  logic [7:0]    last_d = '0;
  logic [AW-1:0] ld_addr [16];
  logic          busy = 1'b0, loading = 1'b0, we_prev = 1'b1, oe_prev = 1'b1;
  int busy_cnt = 0, busy_len = 100, gap = 0, we_low = 0;
  int we_falls = 0, ld_n = 0, polls = 0, max_gap = 0;
  bit strobe_bad = 0, contention_bad = 0;

  initial begin
    for (int i = 0; i < 2048; i++) begin
      arr[i]    = 8'(i) ^ 8'h5A;
      shadow[i] = 8'(i) ^ 8'h5A;
    end
  end

  assign mem_dq_i = (!mem_ce_n && !mem_oe_n) ?
                    ((busy && mem_addr == last_a) ? {~last_d[7], last_d[6:0]} : arr[mem_addr]) :
                    8'h00;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_dq_oe && (!mem_oe_n || mem_ce_n)) contention_bad = 1;
      if (!mem_we_n && (mem_ce_n || !mem_oe_n)) strobe_bad = 1;
      if (we_prev && !mem_we_n && !mem_ce_n) begin
        if (loading && gap > max_gap) max_gap = gap;
        ld_addr[ld_n % 16] = mem_addr;
        ld_n++;
        we_falls++;
        gap = 0;
        loading = 1;
        pend_pg = mem_addr;
      end else if (loading) begin
        gap++;
      end
      if (!mem_we_n) we_low++;
      if (!we_prev && mem_we_n) begin
        if (we_low != PULSE) strobe_bad = 1;
        we_low = 0;
        pend_d[mem_addr[3:0]] = mem_dq_o;
        pend_m[mem_addr[3:0]] = 1'b1;
        last_a = mem_addr;
        last_d = mem_dq_o;
      end
      if (oe_prev && !mem_oe_n && mem_addr == last_a) polls++;
      if (loading && gap > DEV_QUIET && !busy) begin
        loading  = 0;
        busy     = 1;
        busy_cnt = busy_len;
      end else if (busy) begin
        if (busy_cnt == 0) begin
          for (int i = 0; i < 16; i++)
            if (pend_m[i]) arr[{pend_pg[AW-1:4], 4'(i)}] = pend_d[i];
          pend_m = '0;
          busy   = 0;
        end else begin
          busy_cnt--;
        end
      end
      we_prev = mem_we_n;
      oe_prev = mem_oe_n;
    end
  end

  // ---------------- checking ----------------
  int n_chk = 0, n_fail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
    return seed + 8'(i * 83);
  endfunction

  task automatic run(input bit wr, input logic [AW-1:0] a, input int cnt,
                     input logic [7:0] seed, input int send,
                     output logic [1:0] st, output logic [7:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_count = 5'(cnt);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (wr && !rsp_valid) begin
      for (int i = 0; i < send; i++) begin
        wd_valid = 1'b1;
        wd_data  = pat(seed, i);
        while (!wd_ready && !rsp_valid) @(negedge clk);
        if (rsp_valid) break;
        if (i == 0) chk("R11 req_ready low during load", req_ready, 0);
        @(negedge clk);
      end
      wd_valid = 1'b0;
    end
    while (!rsp_valid) @(negedge clk);
    st = rsp_status;
    rd = rsp_data;
    @(negedge clk);
  endtask

  // fields: [26] write, [25:15] addr, [14:10] count, [9:2] seed, [1:0] expected status
  localparam logic [26:0] VEC [10] = '{
    {1'b1, 11'h010, 5'd16, 8'h11, 2'd0},
    {1'b1, 11'h123, 5'd5,  8'h80, 2'd0},
    {1'b1, 11'h7FF, 5'd1,  8'hC3, 2'd0},
    {1'b1, 11'h00E, 5'd3,  8'h01, 2'd1},
    {1'b1, 11'h040, 5'd0,  8'h02, 2'd1},
    {1'b1, 11'h050, 5'd17, 8'h03, 2'd1},
    {1'b0, 11'h012, 5'd0,  8'h00, 2'd0},
    {1'b0, 11'h7FF, 5'd0,  8'h00, 2'd0},
    {1'b1, 11'h20F, 5'd1,  8'h7E, 2'd0},
    {1'b1, 11'h201, 5'd16, 8'h04, 2'd1}
  };

  initial begin : main
    logic [1:0] st;
    logic [7:0] rd;
    int falls0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 ce_n", mem_ce_n, 1);
    chk("R1 oe_n", mem_oe_n, 1);
    chk("R1 we_n", mem_we_n, 1);
    chk("R1 dq_oe", mem_dq_oe, 0);
    chk("R1 req_ready", req_ready, 1);
    chk("R1 wd_ready/rsp_valid", {wd_ready, rsp_valid}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    foreach (VEC[v]) begin
      automatic bit wr = VEC[v][26];
      automatic logic [AW-1:0] a = VEC[v][25:15];
      automatic int cnt = int'(VEC[v][14:10]);
      automatic logic [7:0] seed = VEC[v][9:2];
      automatic logic [1:0] ex = VEC[v][1:0];
      falls0 = we_falls; ld_n = 0; polls = 0;
      run(wr, a, cnt, seed, cnt, st, rd);
      if (!wr) begin
        chk("R10 read status", st, 0);
        chk("R10 read data", rd, shadow[a]);
      end else if (ex == 2'd1) begin
        chk("R2 range status", st, 1);
        chk("R2 no strobe on reject", we_falls - falls0, 0);
      end else begin
        chk("R8 write status", st, 0);
        chk("R8 not busy at done", busy, 0);
        chk("R8 repeated polls", polls >= 2, 1);
        chk("R8 final byte", rd, pat(seed, cnt - 1));
        chk("R3 strobe count", ld_n, cnt);
        for (int k = 0; k < cnt; k++) begin
          chk("R3 load address", ld_addr[k], a + AW'(k));
          shadow[a + AW'(k)] = pat(seed, k);
        end
        for (int k = 0; k < cnt; k++) begin
          run(1'b0, a + AW'(k), 0, 8'h00, 0, st, rd);
          chk("R3 readback", rd, shadow[a + AW'(k)]);
        end
      end
    end

    // R7: stream stalls after two of four bytes
    falls0 = we_falls;
    run(1'b1, 11'h300, 4, 8'h21, 2, st, rd);
    chk("R7 stall status", st, 2);
    chk("R7 no further strobes", we_falls - falls0, 2);
    repeat (300) @(negedge clk);
    shadow[11'h300] = pat(8'h21, 0);
    shadow[11'h301] = pat(8'h21, 1);
    run(1'b0, 11'h302, 0, 8'h00, 0, st, rd);
    chk("R7 unloaded byte untouched", rd, shadow[11'h302]);

    // R9: device stays busy past the polling budget
    busy_len = 1500;
    run(1'b1, 11'h400, 2, 8'h35, 2, st, rd);
    chk("R9 timeout status", st, 3);
    chk("R9 device still busy", busy, 1);
    repeat (1700) @(negedge clk);
    busy_len = 100;
    shadow[11'h400] = pat(8'h35, 0);
    shadow[11'h401] = pat(8'h35, 1);
    run(1'b0, 11'h401, 0, 8'h00, 0, st, rd);
    chk("R9 data lands after timeout", rd, shadow[11'h401]);

    chk("R4 strobe framing and width", strobe_bad, 0);
    chk("R5 no bus contention", contention_bad, 0);
    chk("R6 load gap within window", max_gap < WIN, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule